// File: doc/BRIEF.md
# Population-Count Condition Flags

This block keeps two extra condition flags beside the usual signed-overflow flag of a 32-bit datapath. It also evaluates two conditional-branch predicates from them. The first flag, the sparse flag, looks only at the bits from the highest set bit down to bit 0. It is set when those bits hold strictly more zeros than ones. The second flag, the weight flag, is set when the whole word holds exactly a chosen number of one bits, four by default.

The surrounding pipeline presents one operation per cycle on `op_valid`, together with its class and its 32-bit value. For an add, the value is the sum and `add_ovf` is the adder's signed-overflow bit. For a move, the value is the source operand. The block has no back-pressure: it accepts every operation on the cycle `op_valid` is high, so no ready signal exists.

The branch-taken output is combinational from the registered flags and the predicate select. A branch unit can therefore query it in the cycle after the flag-setting operation. The adder, instruction decode and program counter stay outside.

Top module: `popflag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `sparse_flag`, `weight_flag` and `ovf_flag` to 0 at the next rising edge.
- R2: When the flags are loaded, `sparse_flag` becomes 1 exactly when the bits from the highest set bit down to bit 0 contain strictly more zeros than ones. A value with bit 31 set counts all 32 bits.
- R3: When the flags are loaded, `weight_flag` becomes 1 exactly when the value has WEIGHT (default 4) one bits anywhere in the word.
- R4: An add, `op_cls` = 2'b01 with `op_valid` high, loads `sparse_flag` and `weight_flag` from `op_value` and loads `ovf_flag` from `add_ovf`.
- R5: A move, `op_cls` = 2'b10 with `op_valid` high, loads `sparse_flag` and `weight_flag` from `op_value` and leaves `ovf_flag` unchanged.
- R6: All three flags hold their values when `op_valid` is low, or when `op_cls` is 2'b00 or 2'b11.
- R7: Loading the value 0 gives `sparse_flag` = 0 and `weight_flag` = 0.
- R8: `br_taken` equals `sparse_flag & ~ovf_flag` when `br_sel` = 0, and `weight_flag & ~ovf_flag` when `br_sel` = 1. It follows a change of `br_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_cls | input | 2 | 01 add, 10 move, 00/11 other |
| op_value | input | 32 | Sum for an add, source for a move |
| add_ovf | input | 1 | Adder signed-overflow bit, used on an add |
| br_sel | input | 1 | 0 selects the sparse predicate, 1 the weight predicate |
| sparse_flag | output | 1 | Registered sparse flag |
| weight_flag | output | 1 | Registered weight flag |
| ovf_flag | output | 1 | Registered overflow flag |
| br_taken | output | 1 | Selected branch predicate |

## Verification
Each flag is due one rising edge after the operation that loads it. The bench drives an operation on the falling edge and lets the following rising edge register it. It then samples the flags at the next falling edge, before the next operation is driven. `br_taken` has no register on its path. The bench therefore changes `br_sel` in the middle of a low clock phase and samples it one time unit later, inside the same cycle. Every 16-bit value and a set of wide and random values are swept through both the add and the move classes.

// File: rtl/popflag_pkg.sv
package popflag_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    OPC_NONE = 2'b00,
    OPC_ADD  = 2'b01,
    OPC_MOVE = 2'b10,
    OPC_RSVD = 2'b11
  } op_cls_e;

  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/popflag_msb_len.sv
// Number of significant bits: index of the highest set bit plus one, 0 for zero.
module popflag_msb_len #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     value,
  output logic [CNT_W-1:0] sig_len
);
  always_comb begin
    sig_len = '0;
    for (int i = 0; i < W; i++) begin
      if (value[i]) sig_len = CNT_W'(i + 1);
    end
  end
endmodule

// File: rtl/popflag_ones.sv
// Population count of a word.
module popflag_ones #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     value,
  output logic [CNT_W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + {{(CNT_W-1){1'b0}}, value[i]};
    end
  end
endmodule

// File: rtl/popflag_eval.sv
// Combinational flag decision for one value.
module popflag_eval #(
  parameter int unsigned W      = 32,
  parameter int unsigned WEIGHT = 4,
  parameter int unsigned CNT_W  = $clog2(W + 1)
) (
  input  logic [W-1:0] value,
  output logic         sparse,
  output logic         weight
);
  logic [CNT_W-1:0] sig_len;
  logic [CNT_W-1:0] ones;

  popflag_msb_len #(.W(W), .CNT_W(CNT_W)) u_len (
    .value   (value),
    .sig_len (sig_len)
  );

  popflag_ones #(.W(W), .CNT_W(CNT_W)) u_ones (
    .value (value),
    .ones  (ones)
  );

  // zeros = sig_len - ones; zeros > ones  <=>  sig_len > 2*ones
  always_comb begin
    sparse = ({1'b0, sig_len} > {ones, 1'b0});
    weight = (ones == CNT_W'(WEIGHT));
  end
endmodule

// File: rtl/popflag_unit.sv
module popflag_unit
  import popflag_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned WEIGHT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [1:0]   op_cls,
  input  logic [W-1:0] op_value,
  input  logic         add_ovf,
  input  logic         br_sel,
  output logic         sparse_flag,
  output logic         weight_flag,
  output logic         ovf_flag,
  output logic         br_taken
);
  localparam int unsigned CW = $clog2(W + 1);

  logic ev_sparse, ev_weight;
  logic is_add, is_move, do_load;

  popflag_eval #(.W(W), .WEIGHT(WEIGHT), .CNT_W(CW)) u_eval (
    .value  (op_value),
    .sparse (ev_sparse),
    .weight (ev_weight)
  );

  always_comb begin
    is_add  = op_valid && (op_cls == OPC_ADD);
    is_move = op_valid && (op_cls == OPC_MOVE);
    do_load = is_add || is_move;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sparse_flag <= 1'b0;
      weight_flag <= 1'b0;
      ovf_flag    <= 1'b0;
    end else begin
      if (do_load) begin
        sparse_flag <= ev_sparse;
        weight_flag <= ev_weight;
      end
      if (is_add) ovf_flag <= add_ovf;
    end
  end

  always_comb begin
    br_taken = (br_sel ? weight_flag : sparse_flag) && !ovf_flag;
  end

  a_r4_ovf_load: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_cls == OPC_ADD) |=> (ovf_flag == $past(add_ovf)));

  a_r5_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_cls == OPC_MOVE) |=> $stable(ovf_flag));

  a_r6_hold_all: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_cls == OPC_NONE || op_cls == OPC_RSVD) |=>
      ($stable(sparse_flag) && $stable(weight_flag) && $stable(ovf_flag)));

  a_r7_zero_clear: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_cls == OPC_ADD || op_cls == OPC_MOVE) && op_value == '0) |=>
      (!sparse_flag && !weight_flag));

  a_r2_sparse_needs_zero_msb: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_cls == OPC_MOVE && (&op_value)) |=> !sparse_flag);

  a_r8_no_take_on_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> !br_taken);
endmodule

// File: tb/popflag_unit_bench.sv
module popflag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_cls = 2'b00;
  logic [31:0] op_value = '0;
  logic        add_ovf = 1'b0;
  logic        br_sel = 1'b0;
  logic        sparse_flag, weight_flag, ovf_flag, br_taken;

  int checks = 0;
  int errors = 0;
  logic m_s = 1'b0, m_w = 1'b0, m_o = 1'b0;

  always #5 clk = ~clk;

  popflag_unit u_popflag_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_cls(op_cls),
    .op_value(op_value), .add_ovf(add_ovf), .br_sel(br_sel),
    .sparse_flag(sparse_flag), .weight_flag(weight_flag),
    .ovf_flag(ovf_flag), .br_taken(br_taken)
  );

  function automatic logic ref_sparse(input logic [31:0] v);
    int len = 0;
    int ones = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) begin
        len = i + 1;
        ones++;
      end
    end
    return (len - ones) > ones;
  endfunction

  function automatic logic ref_weight(input logic [31:0] v);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += int'(v[i]);
    return ones == 4;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b value=%h", req, act, exp, op_value);
    end
  endtask

  // Apply one operation on the falling edge; check after the next rising edge.
  task automatic apply(input logic v, input logic [1:0] c,
                       input logic [31:0] val, input logic ov, input string req);
    op_valid = v; op_cls = c; op_value = val; add_ovf = ov;
    if (v && (c == 2'b01 || c == 2'b10)) begin
      m_s = ref_sparse(val);
      m_w = ref_weight(val);
    end
    if (v && c == 2'b01) m_o = ov;
    @(negedge clk);
    chk({req, " sparse"}, sparse_flag, m_s);
    chk({req, " weight"}, weight_flag, m_w);
    chk({req, " ovf"}, ovf_flag, m_o);
  endtask

  task automatic check_branch();
    br_sel = 1'b0; #1;
    chk("R8 sel0", br_taken, m_s & ~m_o);
    br_sel = 1'b1; #1;
    chk("R8 sel1", br_taken, m_w & ~m_o);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    op_valid = 1'b1; op_cls = 2'b01; add_ovf = 1'b1; op_value = 32'h0000_0012;
    @(negedge clk);
    chk("R1 sparse", sparse_flag, 1'b0);
    chk("R1 weight", weight_flag, 1'b0);
    chk("R1 ovf", ovf_flag, 1'b0);
    rst = 1'b0;

    apply(1'b1, 2'b10, 32'h0000_0012, 1'b1, "R5 R2 eighteen");
    chk("R2 eighteen", sparse_flag, 1'b1);
    chk("R5 ovf held", ovf_flag, 1'b0);
    apply(1'b1, 2'b01, 32'hFFFF_FFEE, 1'b0, "R4 minus18");
    chk("R2 minus18", sparse_flag, 1'b0);
    chk("R3 minus18", weight_flag, 1'b0);
    apply(1'b1, 2'b01, 32'h0000_0000, 1'b1, "R7 zero");
    chk("R7 zero sparse", sparse_flag, 1'b0);
    chk("R4 ovf loaded", ovf_flag, 1'b1);
    check_branch();
    apply(1'b1, 2'b10, 32'hFFFF_FFFF, 1'b1, "R5 ones");
    check_branch();
    apply(1'b1, 2'b10, 32'h0000_0024, 1'b0, "R2 100100");
    apply(1'b1, 2'b10, 32'h0000_001B, 1'b0, "R3 11011");
    chk("R3 11011", weight_flag, 1'b1);
    apply(1'b1, 2'b10, 32'h0000_001F, 1'b0, "R3 11111");
    for (int b = 0; b < 32; b++) apply(1'b1, 2'b10, 32'h1 << b, 1'b0, "R2 R3 single");

    // R6: hold under idle and non-loading classes
    apply(1'b1, 2'b01, 32'h0000_0F00, 1'b0, "R4 setup");
    apply(1'b0, 2'b01, 32'h0000_0001, 1'b1, "R6 invalid");
    apply(1'b1, 2'b00, 32'h0000_0001, 1'b1, "R6 cls00");
    apply(1'b1, 2'b11, 32'hFFFF_FFFF, 1'b1, "R6 cls11");
    check_branch();

    for (int v = 0; v < 65536; v++) begin
      apply(1'b1, (v % 3 == 0) ? 2'b01 : 2'b10, 32'(v), v[4], "R2 R3 sweep");
      if (v % 97 == 0) check_branch();
    end
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      apply(1'b1, 2'(n % 4), r, r[7], "R2 R3 R6 random");
      if (n % 5 == 0) check_branch();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule